// File: doc/BRIEF.md
# Two-Wide Next Fetch Address Selector

This block chooses where the front end fetches next. Each cycle the front end fetches a pair of adjacent 4-byte instructions at `fetch_pc` and `fetch_pc + 4`. A small direct-mapped branch target buffer is looked up for both slots. A hit tells the selector that the slot holds a control-flow instruction, and it gives the kind of that instruction and its stored target. A separate predictor supplies a per-slot taken bit. The selector uses that bit only for conditional branches.

The selector walks the two slots in program order. The first slot that is predicted taken supplies the next address, and everything after it is dropped. If no slot is taken, fetch continues at `fetch_pc + 8`. Calls push their fall-through address onto an eight-entry return stack. Returns pop that stack and use the popped value as their target. A resolved redirect from the back end beats every front-end source. It also restores the stack position from a checkpoint that travels with the redirect. The back end takes that checkpoint from `ras_ptr` and `ras_cnt`.

The selector is combinational from fetch inputs to outputs. Buffer contents and stack state change on the clock edge.

Top module: `fetch_next_sel`

## Requirements
- R1: With fetch valid, no redirect and no taken slot, next_pc is fetch_pc + 8 and slot_valid is 2'b11.
- R2: When slot 0 (at fetch_pc) is taken, next_pc is slot 0's target and slot_valid is 2'b01; slot 1 is nullified and ignored for prediction.
- R3: When slot 0 is not taken and slot 1 (at fetch_pc + 4) is taken, next_pc is slot 1's target and slot_valid is 2'b11.
- R4: A slot is a branch only on a buffer hit. A conditional branch (kind code 0) is taken exactly when its pred_taken bit is 1 (bit 0 belongs to slot 0). On a buffer miss the slot falls through whatever its taken bit says.
- R5: Unconditional jumps (kind 1), calls (kind 2) and indirect jumps (kind 4) are always taken, with next_pc taken from the buffer entry.
- R6: A taken call raises ras_push, with ras_push_addr set to the call's address + 4, and ras_ptr advances by one on the next edge.
- R7: A taken return (kind 3) on a non-empty stack raises ras_pop and uses the top stack entry as next_pc; ras_push and ras_pop are never high together.
- R8: A return on an empty stack (ras_cnt = 0) is not taken, raises no ras_pop, and fetch falls through.
- R9: The stack holds 8 entries. ras_cnt saturates at 8, and a push on a full stack overwrites the oldest entry.
- R10: redir_valid forces next_pc to redir_pc, slot_valid to 2'b00, and no push or pop. On the next edge ras_ptr and ras_cnt take redir_ras_ptr and redir_ras_cnt, and the stack contents are kept.
- R11: A buffer write on upd_valid becomes visible from the next cycle. The buffer is indexed by pc[5:2] and tagged with the upper address bits, so a same-index lookup with a different tag misses.
- R12: With fetch_valid low and no redirect, next_pc equals fetch_pc, slot_valid is 2'b00, and there is no stack action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch pair is presented this cycle |
| fetch_pc | input | 32 | Address of slot 0 |
| pred_taken | input | 2 | Direction guess per slot, bit 0 = slot 0 |
| upd_valid | input | 1 | Write one buffer entry |
| upd_pc | input | 32 | Branch address for the write |
| upd_kind | input | 3 | 0 cond, 1 jump, 2 call, 3 return, 4 indirect |
| upd_target | input | 32 | Target stored in the entry |
| redir_valid | input | 1 | Back-end redirect |
| redir_pc | input | 32 | Resolved fetch address |
| redir_ras_ptr | input | 3 | Checkpointed stack pointer |
| redir_ras_cnt | input | 4 | Checkpointed stack occupancy |
| next_pc | output | 32 | Selected next fetch address |
| slot_valid | output | 2 | Slots that survive, bit 0 = slot 0 |
| ras_push | output | 1 | A call pushes this cycle |
| ras_push_addr | output | 32 | Address being pushed |
| ras_pop | output | 1 | A return pops this cycle |
| ras_ptr | output | 3 | Next write position of the stack |
| ras_cnt | output | 4 | Valid stack entries, 0 to 8 |

## Verification
The hardest case to reach is wrap-around on overflow. It only differs from a saturating stack after more pushes than there are entries, followed by a full drain. The stimulus first pushes one distinct return address and then eight copies of a second address. The next eight pops must all yield the second address, and a ninth return must fall through on an empty stack. The checkpoint restore is reached by redirecting after two pushes with a checkpoint that names the older entry. The following return must pop that older value rather than the most recent one.

// File: rtl/fetch_next_sel.sv
module fetch_next_sel #(
  parameter int AW    = 32,
  parameter int BTB_N = 16,
  parameter int RAS_N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_valid,
  input  logic [AW-1:0]              fetch_pc,
  input  logic [1:0]                 pred_taken,
  input  logic                       upd_valid,
  input  logic [AW-1:0]              upd_pc,
  input  logic [2:0]                 upd_kind,
  input  logic [AW-1:0]              upd_target,
  input  logic                       redir_valid,
  input  logic [AW-1:0]              redir_pc,
  input  logic [$clog2(RAS_N)-1:0]   redir_ras_ptr,
  input  logic [$clog2(RAS_N+1)-1:0] redir_ras_cnt,
  output logic [AW-1:0]              next_pc,
  output logic [1:0]                 slot_valid,
  output logic                       ras_push,
  output logic [AW-1:0]              ras_push_addr,
  output logic                       ras_pop,
  output logic [$clog2(RAS_N)-1:0]   ras_ptr,
  output logic [$clog2(RAS_N+1)-1:0] ras_cnt
);
  localparam int IW = $clog2(BTB_N);
  localparam int TW = AW - IW - 2;
  localparam int PW = $clog2(RAS_N);
  localparam int CW = $clog2(RAS_N + 1);
  localparam logic [2:0] K_COND = 3'd0, K_JUMP = 3'd1, K_CALL = 3'd2,
                         K_RET  = 3'd3, K_IND  = 3'd4;

  logic [BTB_N-1:0] bv;
  logic [TW-1:0]    btag [BTB_N];
  logic [2:0]       bkind[BTB_N];
  logic [AW-1:0]    btgt [BTB_N];
  logic [AW-1:0]    rmem [RAS_N];

  logic [AW-1:0] rtop;
  assign rtop = rmem[ras_ptr - PW'(1)];

  logic [1:0]    take;
  logic [2:0]    skind [2];
  logic [AW-1:0] sdest [2];
  logic [AW-1:0] sfall [2];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [AW-1:0] spc;
    logic [IW-1:0] idx;
    logic          hit;
    assign spc      = fetch_pc + AW'(4 * s);
    assign idx      = spc[IW+1:2];
    assign hit      = bv[idx] && (btag[idx] == spc[AW-1:IW+2]);
    assign skind[s] = bkind[idx];
    assign sfall[s] = spc + AW'(4);
    assign sdest[s] = (bkind[idx] == K_RET) ? rtop : btgt[idx];
    always_comb begin
      take[s] = 1'b0;
      if (hit) begin
        case (bkind[idx])
          K_COND:                take[s] = pred_taken[s];
          K_JUMP, K_CALL, K_IND: take[s] = 1'b1;
          K_RET:                 take[s] = (ras_cnt != '0);
          default:               take[s] = 1'b0;
        endcase
      end
    end
  end

  logic       act;
  logic       win;
  logic       any;
  logic [2:0] wkind;
  assign act   = fetch_valid && !redir_valid;
  assign win   = !take[0];
  assign any   = |take;
  assign wkind = skind[win];

  always_comb begin
    if (redir_valid) begin
      next_pc    = redir_pc;
      slot_valid = 2'b00;
    end else if (!fetch_valid) begin
      next_pc    = fetch_pc;
      slot_valid = 2'b00;
    end else if (take[0]) begin
      next_pc    = sdest[0];
      slot_valid = 2'b01;
    end else if (take[1]) begin
      next_pc    = sdest[1];
      slot_valid = 2'b11;
    end else begin
      next_pc    = fetch_pc + AW'(8);
      slot_valid = 2'b11;
    end
  end

  assign ras_push      = act && any && (wkind == K_CALL);
  assign ras_pop       = act && any && (wkind == K_RET);
  assign ras_push_addr = sfall[win];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bv      <= '0;
      ras_ptr <= '0;
      ras_cnt <= '0;
    end else begin
      if (upd_valid) bv[upd_pc[IW+1:2]] <= 1'b1;
      if (redir_valid) begin
        ras_ptr <= redir_ras_ptr;
        ras_cnt <= redir_ras_cnt;
      end else if (ras_push) begin
        ras_ptr <= ras_ptr + PW'(1);
        if (ras_cnt != CW'(RAS_N)) ras_cnt <= ras_cnt + CW'(1);
      end else if (ras_pop) begin
        ras_ptr <= ras_ptr - PW'(1);
        ras_cnt <= ras_cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid) begin
      btag [upd_pc[IW+1:2]] <= upd_pc[AW-1:IW+2];
      bkind[upd_pc[IW+1:2]] <= upd_kind;
      btgt [upd_pc[IW+1:2]] <= upd_target;
    end
    if (ras_push) rmem[ras_ptr] <= ras_push_addr;
  end

  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid != 2'b10); // R2
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_push && ras_pop)); // R7
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ras_push |=> ras_ptr == PW'($past(ras_ptr) + PW'(1))); // R6
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ras_pop |-> ras_cnt != '0); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ras_cnt <= CW'(RAS_N)); // R9
  AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (next_pc == redir_pc && slot_valid == 2'b00 && !ras_push && !ras_pop)); // R10
  AST_REDIR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (ras_ptr == $past(redir_ras_ptr) && ras_cnt == $past(redir_ras_cnt))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !redir_valid) |-> (next_pc == fetch_pc && slot_valid == 2'b00 && !ras_push && !ras_pop)); // R12
endmodule

// File: tb/fetch_next_sel_tb.sv
module fetch_next_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [1:0]  pred_taken = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [2:0]  upd_kind = '0;
  logic [31:0] upd_target = '0;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_pc = '0;
  logic [2:0]  redir_ras_ptr = '0;
  logic [3:0]  redir_ras_cnt = '0;
  logic [31:0] next_pc;
  logic [1:0]  slot_valid;
  logic        ras_push;
  logic [31:0] ras_push_addr;
  logic        ras_pop;
  logic [2:0]  ras_ptr;
  logic [3:0]  ras_cnt;

  always #10 clk = ~clk;

  fetch_next_sel dut_i (.*);

  typedef struct {
    logic [31:0] nxt;
    logic [1:0]  sv;
    logic        push;
    logic [31:0] paddr;
    logic        pop;
    logic [3:0]  cnt;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(next_pc == it.nxt, it.tag, "next_pc", next_pc, it.nxt);
      chk(slot_valid == it.sv, it.tag, "slot_valid", 32'(slot_valid), 32'(it.sv));
      chk(ras_push == it.push, it.tag, "ras_push", 32'(ras_push), 32'(it.push));
      if (it.push) chk(ras_push_addr == it.paddr, it.tag, "ras_push_addr", ras_push_addr, it.paddr);
      chk(ras_pop == it.pop, it.tag, "ras_pop", 32'(ras_pop), 32'(it.pop));
      chk(ras_cnt == it.cnt, it.tag, "ras_cnt", 32'(ras_cnt), 32'(it.cnt));
    end
  end

  task automatic step(input bit fv, input logic [31:0] pc, input logic [1:0] tk,
                      input bit rv, input logic [31:0] rpc, input logic [2:0] rptr,
                      input logic [3:0] rcnt,
                      input logic [31:0] enxt, input logic [1:0] esv, input bit epush,
                      input logic [31:0] epaddr, input bit epop, input logic [3:0] ecnt,
                      input string tag);
    item_t it;
    @(posedge clk); #1;
    fetch_valid = fv; fetch_pc = pc; pred_taken = tk;
    redir_valid = rv; redir_pc = rpc; redir_ras_ptr = rptr; redir_ras_cnt = rcnt;
    upd_valid = 1'b0;
    it.nxt = enxt; it.sv = esv; it.push = epush; it.paddr = epaddr;
    it.pop = epop; it.cnt = ecnt; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic fill(input logic [31:0] pc, input logic [2:0] kind, input logic [31:0] tgt);
    step(1'b0, 32'h40, 2'b11, 1'b0, 0, 0, 0, 32'h40, 2'b00, 1'b0, 0, 1'b0, 4'd0, "R12 idle");
    upd_valid = 1'b1; upd_pc = pc; upd_kind = kind; upd_target = tgt;
  endtask

  // fetch without redirect
  task automatic f(input logic [31:0] pc, input logic [1:0] tk, input logic [31:0] enxt,
                   input logic [1:0] esv, input bit epush, input logic [31:0] epaddr,
                   input bit epop, input logic [3:0] ecnt, input string tag);
    step(1'b1, pc, tk, 1'b0, 0, 0, 0, enxt, esv, epush, epaddr, epop, ecnt, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ras_cnt == 0, "R9 reset", "ras_cnt", 32'(ras_cnt), 0);
    chk(ras_ptr == 0, "R9 reset", "ras_ptr", 32'(ras_ptr), 0);

    f(32'h0100, 2'b11, 32'h0108, 2'b11, 0, 0, 0, 4'd0, "R1 R4 empty buffer");
    fill(32'h1000, 3'd0, 32'h2000);
    fill(32'h1004, 3'd1, 32'h3000);
    fill(32'h1010, 3'd2, 32'h5000);
    fill(32'h1018, 3'd4, 32'h6000);
    fill(32'h5020, 3'd3, 32'h0);
    fill(32'h1024, 3'd2, 32'h7000);
    step(1'b0, 32'h40, 2'b00, 1'b0, 0, 0, 0, 32'h40, 2'b00, 1'b0, 0, 1'b0, 4'd0, "R12 idle");

    f(32'h1000, 2'b00, 32'h3000, 2'b11, 0, 0, 0, 4'd0, "R3 R5 slot1 jump");
    f(32'h1000, 2'b01, 32'h2000, 2'b01, 0, 0, 0, 4'd0, "R2 R4 slot0 cond taken");
    f(32'h0FFC, 2'b10, 32'h2000, 2'b11, 0, 0, 0, 4'd0, "R3 R4 slot1 cond taken");
    f(32'h1020, 2'b11, 32'h7000, 2'b11, 1, 32'h1028, 0, 4'd0, "R6 R11 slot1 call, tag miss");
    f(32'h1010, 2'b00, 32'h5000, 2'b01, 1, 32'h1014, 0, 4'd1, "R6 slot0 call");
    f(32'h5020, 2'b00, 32'h1014, 2'b01, 0, 0, 1, 4'd2, "R7 return pops newest");
    f(32'h5020, 2'b00, 32'h1028, 2'b01, 0, 0, 1, 4'd1, "R7 return pops older");
    f(32'h5020, 2'b00, 32'h5028, 2'b11, 0, 0, 0, 4'd0, "R8 empty return");
    f(32'h1018, 2'b00, 32'h6000, 2'b01, 0, 0, 0, 4'd0, "R5 indirect");

    f(32'h1010, 2'b00, 32'h5000, 2'b01, 1, 32'h1014, 0, 4'd0, "R9 first push");
    for (int i = 1; i <= 8; i++)
      f(32'h1020, 2'b00, 32'h7000, 2'b11, 1, 32'h1028, 0, 4'(i), "R9 fill push");
    for (int k = 1; k <= 8; k++)
      f(32'h5020, 2'b00, 32'h1028, 2'b01, 0, 0, 1, 4'(9 - k), "R9 wrapped pop");
    f(32'h5020, 2'b00, 32'h5028, 2'b11, 0, 0, 0, 4'd0, "R9 drained");

    f(32'h1010, 2'b00, 32'h5000, 2'b01, 1, 32'h1014, 0, 4'd0, "R10 push A");
    f(32'h1020, 2'b00, 32'h7000, 2'b11, 1, 32'h1028, 0, 4'd1, "R10 push B");
    step(1'b1, 32'h1010, 2'b11, 1'b1, 32'h9000, 3'd2, 4'd1,
         32'h9000, 2'b00, 0, 0, 0, 4'd2, "R10 redirect beats call");
    f(32'h5020, 2'b00, 32'h1014, 2'b01, 0, 0, 1, 4'd1, "R10 restored top");
    step(1'b0, 32'h40, 2'b00, 1'b1, 32'hA000, 3'd0, 4'd0,
         32'hA000, 2'b00, 0, 0, 0, 4'd0, "R10 redirect while idle");
    f(32'h5020, 2'b00, 32'h5028, 2'b11, 0, 0, 0, 4'd0, "R8 empty after restore");

    @(posedge clk); #1 fetch_valid = 1'b0; redir_valid = 1'b0;
    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule